// File: doc/BRIEF.md
# Quad-Input Program Command Receiver

This block is the serial-clock front end of a flash-style slave. It captures one program command per chip-select frame. While `cs_n` is low, every rising edge of `sclk` samples the four data lines. The first eight edges take an opcode from `dq[0]` alone, most significant bit first. The next six edges take a 24-bit address as nibbles on all four lines, with `dq[3]` holding the high bit of each nibble. After that, every pair of edges assembles one data byte, upper nibble first, and this continues until chip select is released.

The opcode to accept is the parameter `ACCEPT_OP`. When the opcode matches, the receiver publishes the address with its top two bits forced to zero. It then issues a one-cycle strobe for each data byte, together with that byte's index within the frame. A downstream controller consumes the bytes.

When the opcode does not match, the rest of the frame is ignored. When chip select rises, a flag records whether the frame ended exactly on a completed data byte. A high `cs_n` clears the frame sequencing immediately, whether or not `sclk` is running.

Top module: `qpr_rx`

## Requirements
- R1: On the 8th `sclk` rising edge of a frame, `opcode_o` takes the 8 bits sampled on `dq[0]`, first bit as bit 7. `op_match_o` goes to 1 exactly when that value equals `ACCEPT_OP`, and to 0 otherwise.
- R2: Edges 9 to 14 each sample one address nibble, most significant nibble first, with `dq[3]` as the high bit of the nibble. On edge 14 of an accepted frame, `addr_o` is loaded and `addr_valid_o` is high for that one cycle only.
- R3: Bits 23 and 22 of `addr_o` are always 0, whatever was sent on those positions.
- R4: From edge 15 onward, edges alternate between upper nibble and lower nibble, forming byte {upper, lower}. `byte_valid_o` is high for one cycle, with `byte_o` set, after each lower-nibble edge. It is low after each upper-nibble edge.
- R5: `byte_idx_o` is 0 for the first data byte of a frame and rises by 1 for each following byte, modulo 2^`IDX_W`. Bytes keep arriving for as long as `cs_n` stays low.
- R6: When the opcode differs from `ACCEPT_OP`, the frame produces no `addr_valid_o` and no `byte_valid_o` pulse, and `frame_whole_o` is 0 at its end.
- R7: A high `cs_n` restarts the sequence at once. The frame that follows an aborted partial frame is decoded from its own first edge as an opcode.
- R8: On each rising edge of `cs_n`, `frame_whole_o` is updated to 1 only if three things hold: the frame was accepted, it carried at least one data byte, and its last `sclk` edge completed a data byte. Otherwise it is updated to 0. The value holds until the next rise. A high `cs_n` also clears both strobes.
- R9: While `rst` is high, `sclk` edges clear `opcode_o`, `op_match_o`, `addr_o`, `addr_valid_o`, `byte_o` and `byte_valid_o`. A `cs_n` rise during reset clears `frame_whole_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, sampled on its rising edge |
| cs_n | input | 1 | Active-low chip select; high clears the frame sequencing |
| dq | input | 4 | Serial data lines |
| opcode_o | output | 8 | Last captured opcode |
| op_match_o | output | 1 | Captured opcode equals ACCEPT_OP |
| addr_o | output | 24 | Effective address, top two bits zero |
| addr_valid_o | output | 1 | One-cycle pulse when the address completes |
| byte_o | output | 8 | Last assembled data byte |
| byte_valid_o | output | 1 | One-cycle pulse per completed data byte |
| byte_idx_o | output | IDX_W | Index of `byte_o` within its frame |
| frame_whole_o | output | 1 | Frame ended on a completed data byte |

## Verification
The phase counter is the single piece of state that every output depends on. If it is off by even one edge, the symptom shows within the same frame: the opcode is wrong at edge 8, the address is shifted by one nibble at edge 14, or the byte strobes land on the upper nibbles. A broken frame restart shows up in the first frame after an aborted one. A wrong byte index or a wrong wrap appears at the first byte, or after 2^`IDX_W` bytes. A wrong end-of-frame tail appears only at the moment `cs_n` rises, so frames ending after an odd nibble, or after zero data bytes, are swept explicitly.

// File: rtl/qpr_pkg.sv
package qpr_pkg;
  localparam int OP_BITS   = 8;
  localparam int ADDR_NIBS = 6;
  localparam int ADDR_W    = 4 * ADDR_NIBS;
  localparam int HDR_EDGES = OP_BITS + ADDR_NIBS;

  typedef enum logic [1:0] {
    PH_OP   = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } qpr_phase_e;
endpackage

// File: rtl/qpr_seq.sv
module qpr_seq
  import qpr_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             sclk,
  input  logic             rst,
  input  logic             cs_n,
  output qpr_phase_e       phase_o,
  output logic             first_o,
  output logic             op_last_o,
  output logic             addr_last_o,
  output logic             nib_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int CW = $clog2(HDR_EDGES + 1);
  localparam logic [CW-1:0] HDR_END = CW'(HDR_EDGES);
  localparam logic [CW-1:0] OP_END  = CW'(OP_BITS - 1);
  localparam logic [CW-1:0] AD_END  = CW'(HDR_EDGES - 1);
  localparam logic [CW-1:0] OP_CNT  = CW'(OP_BITS);

  logic [CW-1:0]    cnt_q;
  logic             nib_q;
  logic [IDX_W-1:0] idx_q;

  // chip select high clears the sequencing without needing a clock edge
  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      cnt_q <= '0;
      nib_q <= 1'b0;
      idx_q <= '0;
    end else if (rst) begin
      cnt_q <= '0;
      nib_q <= 1'b0;
      idx_q <= '0;
    end else if (cnt_q != HDR_END) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      nib_q <= ~nib_q;
      if (nib_q) idx_q <= idx_q + 1'b1;
    end
  end

  always_comb begin
    if (cnt_q < OP_CNT)         phase_o = PH_OP;
    else if (cnt_q != HDR_END)  phase_o = PH_ADDR;
    else                        phase_o = PH_DATA;
  end

  assign first_o     = (cnt_q == '0);
  assign op_last_o   = (cnt_q == OP_END);
  assign addr_last_o = (cnt_q == AD_END);
  assign nib_o       = nib_q;
  assign idx_o       = idx_q;

  AST_CNT_BOUND: assert property (@(posedge sclk) disable iff (rst || cs_n)
    cnt_q <= HDR_END) else $error("counter past header");                 // R7

  AST_IDX_STEP: assert property (@(posedge sclk) disable iff (rst || cs_n)
    (phase_o == PH_DATA && nib_q) |=> (idx_q == $past(idx_q) + 1'b1))
    else $error("byte index did not advance");                             // R5
endmodule

// File: rtl/qpr_cap.sv
module qpr_cap
  import qpr_pkg::*;
#(
  parameter logic [OP_BITS-1:0] ACCEPT_OP = 8'hB2,
  parameter int                 IDX_W     = 8
) (
  input  logic               sclk,
  input  logic               rst,
  input  logic               cs_n,
  input  logic [3:0]         dq,
  input  qpr_phase_e         phase,
  input  logic               first,
  input  logic               op_last,
  input  logic               addr_last,
  input  logic               nib,
  input  logic [IDX_W-1:0]   idx,
  output logic [OP_BITS-1:0] opcode_o,
  output logic               op_match_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               addr_valid_o,
  output logic [7:0]         byte_o,
  output logic               byte_valid_o,
  output logic [IDX_W-1:0]   byte_idx_o,
  output logic               tail_whole_o
);
  localparam int KEEP = ADDR_W - 2;

  logic [OP_BITS-1:0] op_sh_q, op_q;
  logic               match_q;
  logic [ADDR_W-1:0]  ad_sh_q, ad_q;
  logic [3:0]         hi_q;
  logic [7:0]         byte_q;
  logic [IDX_W-1:0]   bidx_q;
  logic               tail_q;
  logic               av_q, bv_q;
  logic [OP_BITS-1:0] op_next;
  logic [ADDR_W-1:0]  ad_next;

  assign op_next = {op_sh_q[OP_BITS-2:0], dq[0]};
  assign ad_next = {ad_sh_q[ADDR_W-5:0], dq};

  always_ff @(posedge sclk) begin
    if (rst) begin
      op_sh_q <= '0;
      op_q    <= '0;
      match_q <= 1'b0;
      ad_sh_q <= '0;
      ad_q    <= '0;
      hi_q    <= '0;
      byte_q  <= '0;
      bidx_q  <= '0;
      tail_q  <= 1'b0;
    end else if (!cs_n) begin
      tail_q <= match_q && (phase == PH_DATA) && nib;
      case (phase)
        PH_OP: begin
          op_sh_q <= op_next;
          if (first) match_q <= 1'b0;
          if (op_last) begin
            op_q    <= op_next;
            match_q <= (op_next == ACCEPT_OP);
          end
        end
        PH_ADDR: begin
          if (match_q) begin
            ad_sh_q <= ad_next;
            if (addr_last) ad_q <= {2'b00, ad_next[KEEP-1:0]};
          end
        end
        PH_DATA: begin
          if (match_q) begin
            if (!nib) begin
              hi_q <= dq;
            end else begin
              byte_q <= {hi_q, dq};
              bidx_q <= idx;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // strobes drop as soon as chip select is released
  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      av_q <= 1'b0;
      bv_q <= 1'b0;
    end else if (rst) begin
      av_q <= 1'b0;
      bv_q <= 1'b0;
    end else begin
      av_q <= match_q && (phase == PH_ADDR) && addr_last;
      bv_q <= match_q && (phase == PH_DATA) && nib;
    end
  end

  assign opcode_o     = op_q;
  assign op_match_o   = match_q;
  assign addr_o       = ad_q;
  assign addr_valid_o = av_q;
  assign byte_o       = byte_q;
  assign byte_valid_o = bv_q;
  assign byte_idx_o   = bidx_q;
  assign tail_whole_o = tail_q;

  AST_BYTE_GAP: assert property (@(posedge sclk) disable iff (rst || cs_n)
    bv_q |=> !bv_q) else $error("byte strobe too long");                  // R4

  AST_ADDR_ONCE: assert property (@(posedge sclk) disable iff (rst || cs_n)
    av_q |=> !av_q) else $error("address strobe too long");               // R2

  AST_ADDR_MASK: assert property (@(posedge sclk) disable iff (rst || cs_n)
    av_q |-> (ad_q[ADDR_W-1 -: 2] == 2'b00)) else $error("top bits set"); // R3

  AST_REJECT_QUIET: assert property (@(posedge sclk) disable iff (rst || cs_n)
    (bv_q || av_q) |-> match_q) else $error("strobe on rejected frame");  // R6
endmodule

// File: rtl/qpr_eof.sv
module qpr_eof (
  input  logic rst,
  input  logic cs_n,
  input  logic tail_whole,
  output logic frame_whole_o
);
  logic whole_q;

  always_ff @(posedge cs_n) begin
    if (rst) whole_q <= 1'b0;
    else     whole_q <= tail_whole;
  end

  assign frame_whole_o = whole_q;
endmodule

// File: rtl/qpr_rx.sv
module qpr_rx
  import qpr_pkg::*;
#(
  parameter logic [7:0] ACCEPT_OP = 8'hB2,
  parameter int         IDX_W     = 8
) (
  input  logic             rst,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic [3:0]       dq,
  output logic [7:0]       opcode_o,
  output logic             op_match_o,
  output logic [23:0]      addr_o,
  output logic             addr_valid_o,
  output logic [7:0]       byte_o,
  output logic             byte_valid_o,
  output logic [IDX_W-1:0] byte_idx_o,
  output logic             frame_whole_o
);
  qpr_phase_e       phase;
  logic             first, op_last, addr_last, nib, tail_whole;
  logic [IDX_W-1:0] idx;

  qpr_seq #(.IDX_W(IDX_W)) seq_i (
    .sclk(sclk), .rst(rst), .cs_n(cs_n),
    .phase_o(phase), .first_o(first), .op_last_o(op_last),
    .addr_last_o(addr_last), .nib_o(nib), .idx_o(idx)
  );

  qpr_cap #(.ACCEPT_OP(ACCEPT_OP), .IDX_W(IDX_W)) cap_i (
    .sclk(sclk), .rst(rst), .cs_n(cs_n), .dq(dq),
    .phase(phase), .first(first), .op_last(op_last),
    .addr_last(addr_last), .nib(nib), .idx(idx),
    .opcode_o(opcode_o), .op_match_o(op_match_o),
    .addr_o(addr_o), .addr_valid_o(addr_valid_o),
    .byte_o(byte_o), .byte_valid_o(byte_valid_o),
    .byte_idx_o(byte_idx_o), .tail_whole_o(tail_whole)
  );

  qpr_eof eof_i (
    .rst(rst), .cs_n(cs_n), .tail_whole(tail_whole),
    .frame_whole_o(frame_whole_o)
  );
endmodule

// File: tb/qpr_rx_tb_top.sv
`timescale 1ns/1ps
module qpr_rx_tb_top;
  localparam logic [7:0] ACC = 8'hB2;
  localparam int IDX_W = 8;

  logic             rst = 1'b1;
  logic             sclk = 1'b0;
  logic             cs_n = 1'b1;
  logic [3:0]       dq = 4'h0;
  logic [7:0]       opcode_o;
  logic             op_match_o;
  logic [23:0]      addr_o;
  logic             addr_valid_o;
  logic [7:0]       byte_o;
  logic             byte_valid_o;
  logic [IDX_W-1:0] byte_idx_o;
  logic             frame_whole_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  qpr_rx #(.ACCEPT_OP(ACC), .IDX_W(IDX_W)) dut_i (
    .rst(rst), .sclk(sclk), .cs_n(cs_n), .dq(dq),
    .opcode_o(opcode_o), .op_match_o(op_match_o),
    .addr_o(addr_o), .addr_valid_o(addr_valid_o),
    .byte_o(byte_o), .byte_valid_o(byte_valid_o),
    .byte_idx_o(byte_idx_o), .frame_whole_o(frame_whole_o)
  );

  always #2.5 sclk = ~sclk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one edge's worth of data at a falling edge, return at the next one
  task automatic step(input logic [3:0] d);
    dq   = d;
    cs_n = 1'b0;
    @(posedge sclk);
    @(negedge sclk);
  endtask

  task automatic finish_frame(input bit exp_whole);
    cs_n = 1'b1;
    #1;
    chk(frame_whole_o == exp_whole, "R8 frame_whole", {31'b0, frame_whole_o}, {31'b0, exp_whole});
    chk(byte_valid_o == 1'b0, "R8 strobe cleared", {31'b0, byte_valid_o}, 32'h0);
    @(negedge sclk);
    @(negedge sclk);
  endtask

  task automatic send(input logic [7:0] op, input logic [23:0] a, input int nbytes,
                      input bit half, input logic [7:0] seed);
    bit acc;
    logic [7:0] d;
    acc = (op == ACC);
    for (int i = 0; i < 8; i++) step({3'b101, op[7-i]});
    chk(opcode_o == op, "R1 opcode", {24'b0, opcode_o}, {24'b0, op});
    chk(op_match_o == acc, "R1 match", {31'b0, op_match_o}, {31'b0, acc});
    for (int n = 0; n < 6; n++) begin
      step(a[23-4*n -: 4]);
      if (n < 5)
        chk(addr_valid_o == 1'b0, "R2 early strobe", {31'b0, addr_valid_o}, 32'h0);
    end
    chk(addr_valid_o == acc, "R2 R6 addr strobe", {31'b0, addr_valid_o}, {31'b0, acc});
    if (acc) begin
      chk(addr_o == {2'b00, a[21:0]}, "R2 R3 address", {8'b0, addr_o}, {10'b0, a[21:0]});
    end
    for (int b = 0; b < nbytes; b++) begin
      d = 8'((b * 29) + seed);
      step(d[7:4]);
      chk(byte_valid_o == 1'b0, "R4 upper nibble", {31'b0, byte_valid_o}, 32'h0);
      step(d[3:0]);
      chk(byte_valid_o == acc, "R4 R6 byte strobe", {31'b0, byte_valid_o}, {31'b0, acc});
      if (acc) begin
        chk(byte_o == d, "R4 byte", {24'b0, byte_o}, {24'b0, d});
        chk(byte_idx_o == IDX_W'(b), "R5 index", {24'b0, byte_idx_o}, 32'(b % 256));
      end
    end
    if (half) begin
      step(4'hF);
      chk(byte_valid_o == 1'b0, "R4 half byte", {31'b0, byte_valid_o}, 32'h0);
    end
    finish_frame(acc && nbytes > 0 && !half);
  endtask

  initial begin
    logic [7:0] ops [5];
    ops[0] = ACC; ops[1] = ACC ^ 8'h01; ops[2] = 8'h00; ops[3] = 8'hFF; ops[4] = ACC ^ 8'h80;

    // R9: reset with a chip select cycle so every register sees it
    rst = 1'b1;
    repeat (3) @(negedge sclk);
    cs_n = 1'b0;
    repeat (2) @(negedge sclk);
    cs_n = 1'b1;
    @(negedge sclk);
    rst = 1'b0;
    @(negedge sclk);
    chk(opcode_o == 8'h0, "R9 opcode", {24'b0, opcode_o}, 32'h0);
    chk(op_match_o == 1'b0, "R9 match", {31'b0, op_match_o}, 32'h0);
    chk(addr_o == 24'h0, "R9 addr", {8'b0, addr_o}, 32'h0);
    chk(addr_valid_o == 1'b0, "R9 addr strobe", {31'b0, addr_valid_o}, 32'h0);
    chk(byte_o == 8'h0, "R9 byte", {24'b0, byte_o}, 32'h0);
    chk(byte_valid_o == 1'b0, "R9 byte strobe", {31'b0, byte_valid_o}, 32'h0);
    chk(frame_whole_o == 1'b0, "R9 whole", {31'b0, frame_whole_o}, 32'h0);

    // sweep opcodes, byte counts and odd-nibble endings
    for (int o = 0; o < 5; o++)
      for (int nb = 0; nb < 5; nb++)
        for (int h = 0; h < 2; h++)
          send(ops[o], 24'(32'hC0_0000 + o * 32'h13579 + nb * 32'h2468 + h * 32'h111),
               nb, h[0], 8'(o * 17 + nb * 5 + h));

    // R7: abort during address, then a clean frame
    for (int i = 0; i < 8; i++) step({3'b000, ACC[7-i]});
    step(4'hA); step(4'h5); step(4'hC);
    finish_frame(1'b0);
    send(ACC, 24'hFF_1234, 2, 1'b0, 8'h3C);
    chk(addr_o == 24'h3F_1234, "R7 after abort", {8'b0, addr_o}, 32'h3F_1234);

    // R7: abort during the opcode
    for (int i = 0; i < 5; i++) step({3'b000, ACC[7-i]});
    finish_frame(1'b0);
    send(ACC, 24'h80_0001, 1, 1'b0, 8'h77);
    chk(addr_o == 24'h00_0001, "R7 after opcode abort", {8'b0, addr_o}, 32'h1);

    // R5: long frame wraps the index
    send(ACC, 24'h40_ABCD, 260, 1'b0, 8'h11);

    // R6: a rejected frame leaves the accepted address in place
    send(8'h02, 24'h12_3456, 3, 1'b0, 8'h99);
    chk(addr_o == 24'h00_ABCD, "R6 addr untouched", {8'b0, addr_o}, 32'hABCD);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule